// File: doc/BRIEF.md
# DMA Write Posting Buffer

This block parks DMA write traffic coming from an I/O-side producer until a memory-side consumer is ready to retire it. Storage is organised as a small ring of four slots. Each slot holds one cache-line target address, eight 32-bit longwords and a 4-bit byte-enable group for each longword. A slot becomes visible to the consumer only after the producer has finished filling it. Completed slots leave in the order they were completed.

The producer sends one longword per beat. Each beat carries a longword index and its byte enables. A beat flagged as last closes the line. The consumer sees the oldest complete line as one wide word and retires it with a ready/valid handshake. A separate barrier handshake lets the processor side confirm that no posted write remains. The acknowledge is withheld until every completed line has been handed to memory.

Top module: `dma_wpost_buf`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `full` and `bar_ack` are 0.
- R2: `full` is 1 exactly when four completed lines are waiting for the consumer.
- R3: A producer beat presented while `full` is 1 is discarded. It neither changes a stored line nor starts or closes one, so exactly four lines drain afterwards.
- R4: The consumer sees the line address, the eight longwords and their byte enables of the oldest complete line. Longword k sits at `out_data[32k+31:32k]` and its enables at `out_be[4k+3:4k]`.
- R5: Lines reach the consumer in the order their last beats were accepted.
- R6: When a line opens, all of its byte enables start at zero, so a longword that gets no beat reaches the consumer with enables 0.
- R7: A line handed over with `out_valid` and `out_ready` both 1 is removed on that edge. On the next cycle the following line, or nothing, is presented.
- R8: `bar_ack` is 1 only in a cycle that follows a cycle in which no completed line was pending, and it lasts one cycle.
- R9: If `bar_req` is 1, nothing is pending and `bar_ack` is 0, then `bar_ack` is 1 on the next cycle.
- R10: Within one fill, a second beat to the same longword index replaces both the data and the enables of the first.
- R11: The line address is taken from the first accepted beat of a fill. A line being filled stays hidden from the consumer until its last beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer beat present |
| in_addr | input | ADDR_W | Cache-line address; used on the first beat of a fill |
| in_idx | input | IW | Longword index within the line |
| in_data | input | 32 | Longword data |
| in_be | input | 4 | Byte enables for this longword |
| in_last | input | 1 | Beat closes the line |
| full | output | 1 | All slots hold complete lines; producer must wait |
| out_valid | output | 1 | Oldest complete line presented |
| out_ready | input | 1 | Consumer takes the presented line |
| out_addr | output | ADDR_W | Line address |
| out_data | output | LWORDS*32 | Line data |
| out_be | output | LWORDS*4 | Line byte enables |
| bar_req | input | 1 | Barrier request, held until acknowledged |
| bar_ack | output | 1 | One-cycle barrier acknowledge |

## Verification
A wrong head or tail pointer shows at the consumer port on the next presented line. In that case the address, data or enables differ from the queue model, or a line appears out of order or twice. A stuck or lost slot-valid bit shows as a wrong `full` or `out_valid` on the cycle after the edge that should have changed it. A barrier acknowledge that comes early or late differs from the model on the first cycle where they disagree. Stale enables left over from a previous fill appear as soon as a partly written line reaches the head.

// File: rtl/dma_wpost_buf.sv
module dma_wpost_buf #(
  parameter int ADDR_W = 27,
  parameter int DEPTH  = 4,
  parameter int LWORDS = 8,
  localparam int IW    = $clog2(LWORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [IW-1:0]         in_idx,
  input  logic [31:0]           in_data,
  input  logic [3:0]            in_be,
  input  logic                  in_last,
  output logic                  full,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ADDR_W-1:0]     out_addr,
  output logic [LWORDS*32-1:0]  out_data,
  output logic [LWORDS*4-1:0]   out_be,
  input  logic                  bar_req,
  output logic                  bar_ack
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]       vld_q;
  logic [PW-1:0]          head_q, tail_q;
  logic                   open_q, ack_q;
  logic [ADDR_W-1:0]      addr_q [DEPTH];
  logic [LWORDS*32-1:0]   data_q [DEPTH];
  logic [LWORDS*4-1:0]    be_q   [DEPTH];

  logic take, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
  endfunction

  assign full      = &vld_q;
  assign out_valid = vld_q[head_q];
  assign out_addr  = addr_q[head_q];
  assign out_data  = data_q[head_q];
  assign out_be    = be_q[head_q];
  assign bar_ack   = ack_q;
  assign take      = in_valid && !full;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      open_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= bar_req && !(|vld_q) && !ack_q;
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= bump(head_q);
      end
      if (take) begin
        if (in_last) begin
          vld_q[tail_q] <= 1'b1;
          tail_q        <= bump(tail_q);
          open_q        <= 1'b0;
        end else begin
          open_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      if (!open_q) begin
        addr_q[tail_q] <= in_addr;
        be_q[tail_q]   <= '0;
      end
      data_q[tail_q][int'(in_idx)*32 +: 32] <= in_data;
      be_q[tail_q][int'(in_idx)*4 +: 4]     <= in_be;
    end
  end
endmodule

// File: rtl/dma_wpost_buf_chk.sv
module dma_wpost_buf_chk #(
  parameter int ADDR_W = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              full,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              bar_req,
  input logic              bar_ack
);
  // R2
  full_has_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> out_valid);

  // R7
  full_pop_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && out_valid && out_ready) |=> !full);

  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R8
  ack_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bar_ack) |-> $past(!out_valid));

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_ack |=> !bar_ack);

  // R9
  ack_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_req && !out_valid && !bar_ack) |=> bar_ack);
endmodule

bind dma_wpost_buf dma_wpost_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .full(full), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .bar_req(bar_req), .bar_ack(bar_ack)
);

// File: tb/dma_wpost_buf_bench.sv
`timescale 1ns/1ps
module dma_wpost_buf_bench;
  localparam int AW = 27;
  localparam int NL = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0, bar_req = 0;
  logic [AW-1:0] in_addr = '0;
  logic [2:0] in_idx = '0;
  logic [31:0] in_data = '0;
  logic [3:0] in_be = '0;
  logic full, out_valid, bar_ack;
  logic [AW-1:0] out_addr;
  logic [NL*32-1:0] out_data;
  logic [NL*4-1:0] out_be;

  always #2 clk = ~clk;

  dma_wpost_buf #(.ADDR_W(AW), .DEPTH(4), .LWORDS(NL)) u_dma_wpost_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_idx(in_idx), .in_data(in_data), .in_be(in_be), .in_last(in_last),
    .full(full), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .out_be(out_be),
    .bar_req(bar_req), .bar_ack(bar_ack));

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  logic [AW-1:0]  m_addr[$];
  logic [255:0]   m_data[$];
  logic [31:0]    m_be[$];
  logic [AW-1:0]  c_addr = '0;
  logic [255:0]   c_data = '0;
  logic [31:0]    c_be = '0;
  bit             c_open = 0;
  bit             m_ack = 0;

  function automatic logic [255:0] expand(input logic [31:0] be);
    logic [255:0] m;
    for (int i = 0; i < 32; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr.delete(); m_data.delete(); m_be.delete();
      c_open = 0; m_ack = 0;
    end else begin
      bit acc, pp;
      acc = in_valid && (m_addr.size() < 4);
      pp  = out_ready && (m_addr.size() > 0);
      m_ack = bar_req && (m_addr.size() == 0) && !m_ack;
      if (pp) begin
        void'(m_addr.pop_front()); void'(m_data.pop_front()); void'(m_be.pop_front());
      end
      if (acc) begin
        if (!c_open) begin c_addr = in_addr; c_be = '0; c_data = '0; end
        c_data[int'(in_idx)*32 +: 32] = in_data;
        c_be[int'(in_idx)*4 +: 4] = in_be;
        if (in_last) begin
          m_addr.push_back(c_addr); m_data.push_back(c_data); m_be.push_back(c_be);
          c_open = 0;
        end else c_open = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == (m_addr.size() > 0), "R7 R11 out_valid", 256'(out_valid), 256'(m_addr.size() > 0));
      check(full == (m_addr.size() == 4), "R2 full", 256'(full), 256'(m_addr.size() == 4));
      check(bar_ack == m_ack, "R8 bar_ack", 256'(bar_ack), 256'(m_ack));
      if (m_addr.size() > 0) begin
        check(out_addr == m_addr[0], "R4 R5 out_addr", 256'(out_addr), 256'(m_addr[0]));
        check(out_be == m_be[0], "R6 out_be", 256'(out_be), 256'(m_be[0]));
        check((out_data & expand(m_be[0])) == (m_data[0] & expand(m_be[0])), "R4 out_data",
              out_data & expand(m_be[0]), m_data[0] & expand(m_be[0]));
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic beat(input logic [AW-1:0] a, input int i, input logic [31:0] d,
                      input logic [3:0] b, input bit l);
    in_valid = 1; in_addr = a; in_idx = 3'(i); in_data = d; in_be = b; in_last = l;
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic line(input logic [AW-1:0] a);
    for (int i = 0; i < NL; i++) beat(a, i, {a[15:0], 16'(i)}, 4'hF, i == NL-1);
  endtask

  initial begin
    logic [AW-1:0] seen[$];
    int waitc;
    bit got;
    repeat (2) @(negedge clk);
    // R1
    check(!out_valid && !full && !bar_ack, "R1 reset", {out_valid, full, bar_ack}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && !full && !bar_ack, "R1 after reset", {out_valid, full, bar_ack}, 0);

    // R9 barrier on empty
    bar_req = 1;
    @(negedge clk);
    check(bar_ack == 1, "R9 empty ack", 256'(bar_ack), 1);
    bar_req = 0;
    @(negedge clk);

    // R11 partial fill hidden, R6 unwritten enables, R10 overwrite
    beat(27'h100, 2, 32'hAAAA0002, 4'hF, 0);
    beat(27'h1FF, 5, 32'h11111111, 4'h3, 0);
    check(out_valid == 0, "R11 hidden while open", 256'(out_valid), 0);
    beat(27'h1FE, 5, 32'h22222222, 4'hC, 1);
    check(out_addr == 27'h100, "R11 first beat addr", 256'(out_addr), 27'h100);
    check(out_be == 32'h00C00F00, "R6 R10 enables", 256'(out_be), 32'h00C00F00);
    check(out_data[5*32 +: 32] == 32'h22222222, "R10 overwrite data", 256'(out_data[5*32 +: 32]), 32'h22222222);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check(out_valid == 0, "R7 popped", 256'(out_valid), 0);

    // fill four lines, R2 full, R3 stalled beats
    for (int k = 0; k < 4; k++) line(27'(10 + k));
    check(full == 1, "R2 full at four", 256'(full), 1);
    beat(27'h55, 0, 32'hDEADBEEF, 4'hF, 1);
    beat(27'h56, 1, 32'hDEADBEEF, 4'hF, 1);
    check(out_be == 32'hFFFFFFFF, "R3 head untouched", 256'(out_be), 32'hFFFFFFFF);

    // R8 barrier waits for drain
    bar_req = 1;
    repeat (4) @(negedge clk);
    check(bar_ack == 0, "R8 held off", 256'(bar_ack), 0);
    out_ready = 1;
    got = 0;
    waitc = 0;
    while (!got && waitc < 20) begin
      if (out_valid) seen.push_back(out_addr);
      if (bar_ack) begin
        got = 1;
        check(out_valid == 0, "R8 empty at ack", 256'(out_valid), 0);
      end
      @(negedge clk);
      waitc++;
    end
    bar_req = 0;
    check(got, "R8 ack arrives", 256'(got), 1);
    check(seen.size() == 4, "R3 four drained", 256'(seen.size()), 4);
    for (int k = 0; k < 4 && k < seen.size(); k++)
      check(seen[k] == 27'(10 + k), "R5 order", 256'(seen[k]), 256'(10 + k));
    out_ready = 0;
    @(negedge clk);

    // random traffic checked against the model every cycle
    for (int n = 0; n < 3000; n++) begin
      in_valid = ($urandom_range(0, 2) != 0);
      in_addr  = 27'($urandom);
      in_idx   = 3'($urandom);
      in_data  = $urandom;
      in_be    = 4'($urandom);
      in_last  = ($urandom_range(0, 3) == 0);
      out_ready = ($urandom_range(0, 2) == 0);
      if (bar_req && bar_ack) bar_req = 0;
      else if (!bar_req && $urandom_range(0, 19) == 0) bar_req = 1;
      @(negedge clk);
    end
    in_valid = 0;
    bar_req = 0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule